// File: doc/BRIEF.md
# Character Display Register File

This block is the register side of an eight-position dot-matrix character display. It sits on a parallel host bus with an 8-bit data path and a 6-bit address. The bus also has a chip-enable, a write strobe, a read strobe and an active-low module reset. The block keeps the state that a display scanner needs:

- eight character codes, each either an ASCII code or a pointer to one of the user-defined glyphs;
- one flash-attribute bit per character;
- a pointer to a user glyph, plus that glyph's 5-wide by 7-high row storage;
- a control word holding brightness, flash enable and blink enable.

Two control bits do not simply store a value: one blanks the display and one starts a self-test. Each starts a timed internal operation, and the block reports busy until the operation ends. Bus inputs are taken as synchronous to `clk`. A write takes effect on the first clock edge that sees the write strobe high again after a cycle in which it was low with chip-enable low.

The sequencer has four states:

- `ST_IDLE`: ready for writes.
- `ST_HOLD`: the module reset is held.
- `ST_CLEAR`: a timed settle after a clear or after a reset.
- `ST_TEST`: the self-test interval.

Its transitions are:

- IDLE→CLEAR on an accepted control write with bit 7 set.
- IDLE→TEST on an accepted control write with bit 6 set and bit 7 clear.
- any state→HOLD while a reset is requested.
- HOLD→CLEAR when the reset is released.
- CLEAR→IDLE when the count expires.
- TEST→IDLE when the count expires, at which point the result is posted.

Top module: `chardisp_regs`

## Requirements
- R1: After `rst_n` the block is idle (`busy`=0), every character code reads 0x20, every flash bit reads 0, the glyph pointer reads 0 and the control word reads 0x00 (so `duty_pct` is 100).
- R2: A write is accepted only on a rising edge of `wr_n` where `ce_n` was low in the cycle before the edge and is still low at the edge; toggling `wr_n` with `ce_n` high changes nothing.
- R3: `rd_drive` is 1 exactly when `ce_n` and `rd_n` are both low; while `rd_drive` is 0, `rd_data` is 0x00.
- R4: Addresses 0x38..0x3F hold character codes for positions 0..7. Written data with bit 7 set is stored as 0x80 OR data[3:0], which selects a user glyph. Written data with bit 7 clear is stored as data[6:0]. Reads return the stored code.
- R5: Any address with bit 5 low addresses the flash bit selected by address bits 2:0; writes store data bit 0, and reads return it in bit 0 with bits 7:1 zero.
- R6: A write to 0x20..0x27 sets the glyph pointer to data[3:0], and a read there returns the pointer. Address 0x28+r, for r from 0 to 6, reaches row r of the glyph selected by the pointer: writes store data[4:0] and reads return it. Address 0x2F ignores writes and reads as 0.
- R7: The control word is at 0x30..0x37. Bits 2:0 are the brightness code, bit 3 enables flash, bit 4 enables blink, bit 5 is the self-test result (read-only) and bit 6 is self-test running. Reads return bits 6:0, and bit 7 always reads 0.
- R8: `duty_pct` maps brightness codes 0..7 to 100, 80, 53, 40, 27, 20, 13 and 0.
- R9: An accepted control write with bit 7 set blanks all character codes to 0x20 and all flash bits to 0 on that edge, stores data[4:0], and holds `busy` high for `CLEAR_CYCLES` cycles.
- R10: An accepted control write with bit 6 set and bit 7 clear sets bit 6, clears bit 5 and holds `busy` for `TEST_CYCLES` cycles. After that, bit 6 reads 0 and bit 5 reads 1 (pass).
- R11: When bits 7 and 6 are written together, only the clear runs: `busy` lasts `CLEAR_CYCLES` and bit 6 stays 0.
- R12: Every write that arrives while `busy` is high is discarded; reads still work.
- R13: `disp_rst_n` low with `ce_n` high restores the R1 state, except that glyph rows keep their contents. `busy` stays high while the reset is held and for `CLEAR_CYCLES` cycles after the first edge that sees the reset released. `disp_rst_n` low with `ce_n` low is ignored.
- R14: `flash_en` and `blink_en` follow control bits 3 and 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low block reset |
| disp_rst_n | input | 1 | Active-low module reset from the bus, honoured only while ce_n is high |
| ce_n | input | 1 | Active-low chip enable |
| wr_n | input | 1 | Active-low write strobe |
| rd_n | input | 1 | Active-low read strobe |
| addr | input | 6 | Register address; bit 5 separates flash bits from the upper areas |
| wdata | input | 8 | Write data |
| rd_data | output | 8 | Read data, zero when not driven |
| rd_drive | output | 1 | High when the block drives read data onto the bus |
| busy | output | 1 | Timed operation or reset in progress; writes are dropped |
| duty_pct | output | 7 | Brightness as percent duty for the scanner |
| flash_en | output | 1 | Flash attribute enable |
| blink_en | output | 1 | Whole-display blink enable |

## Verification
Two pairs of functions can meet in one cycle. The first pair is clear and self-test start, which are provoked by a single control write carrying both bits. That case is judged on the busy length, which must equal the clear time, and on bit 6 reading 0 afterwards. The second pair is a module reset and an active chip-enable. They are provoked by pulling the reset low while chip-enable is low and then while it is high, and judged on busy and on whether a previously written character survives. A behavioural model in the bench tracks every register and is compared with the outputs and read data on every clock, so writes issued during busy windows are also covered.

// File: rtl/chardisp_pkg.sv
package chardisp_pkg;

    localparam int ADDR_W = 6;
    localparam int DATA_W = 8;
    localparam int SLOT_W = 3;

    localparam logic [DATA_W-1:0] BLANK_CODE = 8'h20;

    localparam int CB_FLASH  = 3;
    localparam int CB_BLINK  = 4;
    localparam int CB_RESULT = 5;
    localparam int CB_TEST   = 6;
    localparam int CB_CLEAR  = 7;

    typedef enum logic [2:0] {
        AR_FLASH,
        AR_UPTR,
        AR_UROW,
        AR_CTRL,
        AR_CHAR
    } area_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HOLD,
        ST_CLEAR,
        ST_TEST
    } op_state_e;

    typedef struct packed {
        logic              valid;
        area_e             area;
        logic [SLOT_W-1:0] idx;
        logic [DATA_W-1:0] data;
    } wr_req_t;

    function automatic area_e area_of(input logic [ADDR_W-1:0] a);
        area_e r;
        if (!a[ADDR_W-1]) begin
            r = AR_FLASH;
        end else begin
            unique case (a[ADDR_W-2 -: 2])
                2'b00:   r = AR_UPTR;
                2'b01:   r = AR_UROW;
                2'b10:   r = AR_CTRL;
                default: r = AR_CHAR;
            endcase
        end
        return r;
    endfunction

    function automatic logic [6:0] duty_of(input logic [2:0] code);
        logic [6:0] p;
        unique case (code)
            3'd0:    p = 7'd100;
            3'd1:    p = 7'd80;
            3'd2:    p = 7'd53;
            3'd3:    p = 7'd40;
            3'd4:    p = 7'd27;
            3'd5:    p = 7'd20;
            3'd6:    p = 7'd13;
            default: p = 7'd0;
        endcase
        return p;
    endfunction

    function automatic logic [DATA_W-1:0] norm_char(input logic [DATA_W-1:0] d);
        return d[DATA_W-1] ? {1'b1, 3'b000, d[3:0]} : {1'b0, d[DATA_W-2:0]};
    endfunction

endpackage

// File: rtl/chardisp_bus_if.sv
module chardisp_bus_if
    import chardisp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output wr_req_t           req
);

    logic wr_n_q;
    logic ce_n_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_n_q <= 1'b1;
            ce_n_q <= 1'b1;
        end else begin
            wr_n_q <= wr_n;
            ce_n_q <= ce_n;
        end
    end

    always_comb begin
        req.valid = wr_n && !wr_n_q && !ce_n_q && !ce_n;
        req.area  = area_of(addr);
        req.idx   = addr[SLOT_W-1:0];
        req.data  = wdata;
    end

endmodule

// File: rtl/chardisp_seq.sv
module chardisp_seq
    import chardisp_pkg::*;
#(
    parameter int CLEAR_CYCLES = 250_000,
    parameter int TEST_CYCLES  = 750_000_000
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      rst_req,
    input  logic      start_clear,
    input  logic      start_test,
    output op_state_e state,
    output logic      busy,
    output logic      test_done
);

    localparam int MAX_CYC = (CLEAR_CYCLES > TEST_CYCLES) ? CLEAR_CYCLES : TEST_CYCLES;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    op_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             load_clear, load_test;
    logic             cnt_zero;

    assign cnt_zero = (cnt_q == '0);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_clear) begin
            cnt_q <= CNT_W'(CLEAR_CYCLES - 1);
        end else if (load_test) begin
            cnt_q <= CNT_W'(TEST_CYCLES - 1);
        end else if (!cnt_zero) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // next-state logic
    always_comb begin
        state_d    = state_q;
        load_clear = 1'b0;
        load_test  = 1'b0;
        if (rst_req) begin
            state_d = ST_HOLD;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start_clear) begin
                        state_d    = ST_CLEAR;
                        load_clear = 1'b1;
                    end else if (start_test) begin
                        state_d   = ST_TEST;
                        load_test = 1'b1;
                    end
                end
                ST_HOLD: begin
                    state_d    = ST_CLEAR;
                    load_clear = 1'b1;
                end
                ST_CLEAR: begin
                    if (cnt_zero) state_d = ST_IDLE;
                end
                ST_TEST: begin
                    if (cnt_zero) state_d = ST_IDLE;
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        state     = state_q;
        busy      = (state_q != ST_IDLE);
        test_done = (state_q == ST_TEST) && cnt_zero && !rst_req;
    end

endmodule

// File: rtl/chardisp_store.sv
module chardisp_store
    import chardisp_pkg::*;
#(
    parameter int NUM_CHARS = 8,
    parameter int UDC_COUNT = 16,
    parameter int UDC_ROWS  = 7,
    parameter int UDC_COLS  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rst_req,
    input  logic              accept,
    input  wr_req_t           req,
    input  logic              start_clear,
    input  logic              start_test,
    input  logic              test_done,
    input  logic              rd_drive,
    input  logic [ADDR_W-1:0] addr,
    output logic [6:0]        ctrl_bits,
    output logic [DATA_W-1:0] rd_data
);

    localparam int PTR_W = $clog2(UDC_COUNT);

    logic [DATA_W-1:0]   char_q  [NUM_CHARS];
    logic                flash_q [NUM_CHARS];
    logic [UDC_COLS-1:0] urow_q  [UDC_COUNT][UDC_ROWS];
    logic [PTR_W-1:0]    uptr_q;
    logic [6:0]          ctrl_q;

    logic wr_char, wr_flash, wr_uptr, wr_urow, wr_ctrl;

    assign wr_char  = accept && (req.area == AR_CHAR);
    assign wr_flash = accept && (req.area == AR_FLASH);
    assign wr_uptr  = accept && (req.area == AR_UPTR);
    assign wr_urow  = accept && (req.area == AR_UROW);
    assign wr_ctrl  = accept && (req.area == AR_CTRL);

    for (genvar s = 0; s < NUM_CHARS; s++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                char_q[s]  <= BLANK_CODE;
                flash_q[s] <= 1'b0;
            end else if (rst_req || start_clear) begin
                char_q[s]  <= BLANK_CODE;
                flash_q[s] <= 1'b0;
            end else begin
                if (wr_char && req.idx == SLOT_W'(s)) begin
                    char_q[s] <= norm_char(req.data);
                end
                if (wr_flash && req.idx == SLOT_W'(s)) begin
                    flash_q[s] <= req.data[0];
                end
            end
        end
    end

    for (genvar g = 0; g < UDC_COUNT; g++) begin : g_glyph
        for (genvar r = 0; r < UDC_ROWS; r++) begin : g_row
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    urow_q[g][r] <= '0;
                end else if (!rst_req && wr_urow &&
                             uptr_q == PTR_W'(g) && req.idx == SLOT_W'(r)) begin
                    urow_q[g][r] <= req.data[UDC_COLS-1:0];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            uptr_q <= '0;
        end else if (rst_req) begin
            uptr_q <= '0;
        end else if (wr_uptr) begin
            uptr_q <= req.data[PTR_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (rst_req) begin
            ctrl_q <= '0;
        end else if (test_done) begin
            ctrl_q[CB_TEST]   <= 1'b0;
            ctrl_q[CB_RESULT] <= 1'b1;
        end else if (wr_ctrl) begin
            ctrl_q[4:0] <= req.data[4:0];
            if (start_test) begin
                ctrl_q[CB_TEST]   <= 1'b1;
                ctrl_q[CB_RESULT] <= 1'b0;
            end
        end
    end

    assign ctrl_bits = ctrl_q;

    always_comb begin
        rd_data = '0;
        if (rd_drive) begin
            unique case (area_of(addr))
                AR_FLASH: rd_data[0] = flash_q[addr[SLOT_W-1:0]];
                AR_UPTR:  rd_data[PTR_W-1:0] = uptr_q;
                AR_UROW: begin
                    if (int'(addr[SLOT_W-1:0]) < UDC_ROWS) begin
                        rd_data[UDC_COLS-1:0] = urow_q[uptr_q][addr[SLOT_W-1:0]];
                    end
                end
                AR_CTRL:  rd_data[6:0] = ctrl_q;
                AR_CHAR:  rd_data = char_q[addr[SLOT_W-1:0]];
                default:  rd_data = '0;
            endcase
        end
    end

endmodule

// File: rtl/chardisp_regs.sv
module chardisp_regs
    import chardisp_pkg::*;
#(
    parameter int NUM_CHARS    = 8,
    parameter int UDC_COUNT    = 16,
    parameter int UDC_ROWS     = 7,
    parameter int UDC_COLS     = 5,
    parameter int CLEAR_CYCLES = 250_000,
    parameter int TEST_CYCLES  = 750_000_000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        disp_rst_n,
    input  logic        ce_n,
    input  logic        wr_n,
    input  logic        rd_n,
    input  logic [5:0]  addr,
    input  logic [7:0]  wdata,
    output logic [7:0]  rd_data,
    output logic        rd_drive,
    output logic        busy,
    output logic [6:0]  duty_pct,
    output logic        flash_en,
    output logic        blink_en
);

    wr_req_t   wr_req;
    op_state_e op_state;
    logic      rst_req;
    logic      accept;
    logic      start_clear, start_test, test_done;
    logic [6:0] ctrl_bits;

    assign rst_req     = !disp_rst_n && ce_n;
    assign rd_drive    = !ce_n && !rd_n;
    assign accept      = wr_req.valid && !busy && !rst_req;
    assign start_clear = accept && (wr_req.area == AR_CTRL) && wr_req.data[CB_CLEAR];
    assign start_test  = accept && (wr_req.area == AR_CTRL) &&
                         !wr_req.data[CB_CLEAR] && wr_req.data[CB_TEST];

    chardisp_bus_if i_bus (
        .clk   (clk),
        .rst_n (rst_n),
        .ce_n  (ce_n),
        .wr_n  (wr_n),
        .addr  (addr),
        .wdata (wdata),
        .req   (wr_req)
    );

    chardisp_seq #(
        .CLEAR_CYCLES (CLEAR_CYCLES),
        .TEST_CYCLES  (TEST_CYCLES)
    ) i_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .rst_req     (rst_req),
        .start_clear (start_clear),
        .start_test  (start_test),
        .state       (op_state),
        .busy        (busy),
        .test_done   (test_done)
    );

    chardisp_store #(
        .NUM_CHARS (NUM_CHARS),
        .UDC_COUNT (UDC_COUNT),
        .UDC_ROWS  (UDC_ROWS),
        .UDC_COLS  (UDC_COLS)
    ) i_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .rst_req     (rst_req),
        .accept      (accept),
        .req         (wr_req),
        .start_clear (start_clear),
        .start_test  (start_test),
        .test_done   (test_done),
        .rd_drive    (rd_drive),
        .addr        (addr),
        .ctrl_bits   (ctrl_bits),
        .rd_data     (rd_data)
    );

    assign duty_pct = duty_of(ctrl_bits[2:0]);
    assign flash_en = ctrl_bits[CB_FLASH];
    assign blink_en = ctrl_bits[CB_BLINK];

endmodule

// File: rtl/chardisp_regs_chk.sv
module chardisp_regs_chk
    import chardisp_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       disp_rst_n,
    input logic       ce_n,
    input logic [5:0] addr,
    input logic [7:0] rd_data,
    input logic       rd_drive,
    input logic       busy,
    input logic [6:0] duty_pct,
    input op_state_e  state,
    input logic [6:0] ctrl_bits,
    input wr_req_t    req
);

    logic hold_req;
    assign hold_req = !disp_rst_n && ce_n;

    // R7: control word top bit never appears on the bus
    a_r7_ctrl_msb_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_drive && addr == 6'h30) |-> (rd_data[7] == 1'b0));

    // R9: an accepted clear write starts a busy window
    a_r9_clear_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (req.valid && req.area == AR_CTRL && req.data[CB_CLEAR] && !busy && !hold_req)
        |=> busy);

    // R10: leaving the test posts the pass result and drops the running bit
    a_r10_result_posted: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && $past(state) == ST_TEST)
        |-> (ctrl_bits[CB_RESULT] && !ctrl_bits[CB_TEST]));

    // R12: while busy no write can move the brightness
    a_r12_busy_freezes_bright: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !hold_req) |=> $stable(duty_pct));

    // R13: a reset request with chip enable high always makes the block busy
    a_r13_reset_busy: assert property (@(posedge clk) disable iff (!rst_n)
        hold_req |=> busy);

endmodule

bind chardisp_regs chardisp_regs_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .disp_rst_n (disp_rst_n),
    .ce_n       (ce_n),
    .addr       (addr),
    .rd_data    (rd_data),
    .rd_drive   (rd_drive),
    .busy       (busy),
    .duty_pct   (duty_pct),
    .state      (op_state),
    .ctrl_bits  (ctrl_bits),
    .req        (wr_req)
);

// File: tb/test_chardisp_regs.sv
module test_chardisp_regs;

    localparam int CLR = 20;
    localparam int TST = 50;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       disp_rst_n = 1'b1;
    logic       ce_n = 1'b1;
    logic       wr_n = 1'b1;
    logic       rd_n = 1'b1;
    logic [5:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rd_data;
    logic       rd_drive;
    logic       busy;
    logic [6:0] duty_pct;
    logic       flash_en;
    logic       blink_en;

    int  n_checks = 0;
    int  n_err = 0;
    bit  done = 0;

    always #4 clk = ~clk;

    chardisp_regs #(
        .CLEAR_CYCLES (CLR),
        .TEST_CYCLES  (TST)
    ) i_chardisp_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .disp_rst_n (disp_rst_n),
        .ce_n       (ce_n),
        .wr_n       (wr_n),
        .rd_n       (rd_n),
        .addr       (addr),
        .wdata      (wdata),
        .rd_data    (rd_data),
        .rd_drive   (rd_drive),
        .busy       (busy),
        .duty_pct   (duty_pct),
        .flash_en   (flash_en),
        .blink_en   (blink_en)
    );

    // ---------------- reference model ----------------
    int m_char [8];
    int m_flash [8];
    int m_row [16][7];
    int m_ptr, m_ctrl, m_mode, m_cnt;   // mode: 0 idle, 1 hold, 2 clear, 3 test
    bit m_pwr, m_pce;

    function automatic void m_reset(bit full);
        for (int i = 0; i < 8; i++) begin
            m_char[i] = 'h20;
            m_flash[i] = 0;
        end
        m_ptr = 0;
        m_ctrl = 0;
        if (full)
            for (int g = 0; g < 16; g++)
                for (int r = 0; r < 7; r++) m_row[g][r] = 0;
    endfunction

    function automatic void m_write(int a, int d);
        if (a < 32) m_flash[a % 8] = d & 1;
        else if (a < 40) m_ptr = d & 15;
        else if (a < 48) begin
            if (a - 40 < 7) m_row[m_ptr][a - 40] = d & 31;
        end else if (a < 56) begin
            if ((d & 'h80) != 0) begin
                m_ctrl = (m_ctrl & 'h20) | (d & 'h1F);
                for (int i = 0; i < 8; i++) begin
                    m_char[i] = 'h20;
                    m_flash[i] = 0;
                end
                m_mode = 2;
                m_cnt = CLR;
            end else if ((d & 'h40) != 0) begin
                m_ctrl = 'h40 | (d & 'h1F);
                m_mode = 3;
                m_cnt = TST;
            end else begin
                m_ctrl = (m_ctrl & 'h20) | (d & 'h1F);
            end
        end else begin
            m_char[a % 8] = ((d & 'h80) != 0) ? ('h80 | (d & 15)) : (d & 'h7F);
        end
    endfunction

    function automatic int m_read(int a);
        if (a < 32) return m_flash[a % 8];
        if (a < 40) return m_ptr;
        if (a < 48) return (a - 40 < 7) ? m_row[m_ptr][a - 40] : 0;
        if (a < 56) return m_ctrl;
        return m_char[a % 8];
    endfunction

    function automatic int pct(int code);
        case (code)
            0: return 100;
            1: return 80;
            2: return 53;
            3: return 40;
            4: return 27;
            5: return 20;
            6: return 13;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_reset(1);
            m_mode = 0;
            m_cnt = 0;
            m_pwr = 1;
            m_pce = 1;
        end else begin
            if (!disp_rst_n && ce_n) begin
                m_reset(0);
                m_mode = 1;
            end else if (m_mode == 1) begin
                m_mode = 2;
                m_cnt = CLR;
            end else if (m_mode != 0) begin
                m_cnt--;
                if (m_cnt == 0) begin
                    if (m_mode == 3) m_ctrl = (m_ctrl & ~'h40) | 'h20;
                    m_mode = 0;
                end
            end else if (wr_n && !m_pwr && !m_pce && !ce_n) begin
                m_write(int'(addr), int'(wdata));
            end
            m_pwr = wr_n;
            m_pce = ce_n;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R12 model busy", int'(busy), (m_mode != 0) ? 1 : 0);
            chk("R8 model duty", int'(duty_pct), pct(m_ctrl & 7));
            chk("R14 model flash_en", int'(flash_en), (m_ctrl >> 3) & 1);
            chk("R14 model blink_en", int'(blink_en), (m_ctrl >> 4) & 1);
            chk("R3 model drive", int'(rd_drive), (!ce_n && !rd_n) ? 1 : 0);
            chk("R4 model rd_data", int'(rd_data),
                (!ce_n && !rd_n) ? m_read(int'(addr)) : 0);
        end
    end

    // ---------------- bus tasks ----------------
    task automatic do_write(input logic [5:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        addr = a; wdata = d; ce_n = 1'b0; wr_n = 1'b0;
        @(posedge clk); #1;
        wr_n = 1'b1;
        @(posedge clk); #1;
        ce_n = 1'b1;
    endtask

    task automatic write_no_ce(input logic [5:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        addr = a; wdata = d; wr_n = 1'b0;
        @(posedge clk); #1;
        wr_n = 1'b1;
        @(posedge clk); #1;
    endtask

    task automatic check_read(input logic [5:0] a, input int exp, input string tag);
        @(posedge clk); #1;
        addr = a; ce_n = 1'b0; rd_n = 1'b0;
        @(negedge clk);
        chk(tag, int'(rd_data), exp);
        @(posedge clk); #1;
        ce_n = 1'b1; rd_n = 1'b1;
    endtask

    task automatic count_busy(output int n);
        n = 0;
        @(negedge clk);
        while (busy && n < 100000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog actual=hung expected=finished");
            finish_run();
        end
    end

    initial begin
        int n;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        @(negedge clk);
        chk("R1 busy", int'(busy), 0);
        chk("R1 duty", int'(duty_pct), 100);
        check_read(6'h30, 'h00, "R1 ctrl");
        check_read(6'h38, 'h20, "R1 char0");
        check_read(6'h3F, 'h20, "R1 char7");
        check_read(6'h00, 0, "R1 flash0");
        check_read(6'h20, 0, "R1 ptr");

        // R4 character codes
        do_write(6'h38, 8'h41);
        do_write(6'h3F, 8'hC5);
        do_write(6'h39, 8'h7F);
        check_read(6'h38, 'h41, "R4 ascii");
        check_read(6'h3F, 'h85, "R4 glyph select");
        check_read(6'h39, 'h7F, "R4 ascii max");

        // R2 write without chip enable
        write_no_ce(6'h3A, 8'h55);
        check_read(6'h3A, 'h20, "R2 no ce");

        // R5 flash bits
        do_write(6'h03, 8'hFF);
        check_read(6'h03, 1, "R5 flash3");
        check_read(6'h1B, 1, "R5 flash alias");
        check_read(6'h04, 0, "R5 flash4");

        // R6 glyph pointer and rows
        do_write(6'h20, 8'h15);
        check_read(6'h20, 5, "R6 ptr");
        do_write(6'h2A, 8'hFF);
        check_read(6'h2A, 'h1F, "R6 row2");
        do_write(6'h2F, 8'h1F);
        check_read(6'h2F, 0, "R6 row7 ignored");
        do_write(6'h20, 8'h03);
        check_read(6'h2A, 0, "R6 other glyph");
        do_write(6'h20, 8'h05);
        check_read(6'h2A, 'h1F, "R6 glyph back");

        // R3 read strobes
        @(posedge clk); #1 addr = 6'h38; ce_n = 1'b0; rd_n = 1'b1;
        @(negedge clk);
        chk("R3 rd high drive", int'(rd_drive), 0);
        chk("R3 rd high data", int'(rd_data), 0);
        @(posedge clk); #1 ce_n = 1'b1; rd_n = 1'b0;
        @(negedge clk);
        chk("R3 ce high drive", int'(rd_drive), 0);
        @(posedge clk); #1 ce_n = 1'b0;
        @(negedge clk);
        chk("R3 both low drive", int'(rd_drive), 1);
        @(posedge clk); #1 ce_n = 1'b1; rd_n = 1'b1;

        // R7 R8 R14 control word
        do_write(6'h30, 8'h3B);
        check_read(6'h30, 'h1B, "R7 ctrl readback");
        chk("R8 duty code3", int'(duty_pct), 40);
        chk("R14 flash_en", int'(flash_en), 1);
        chk("R14 blink_en", int'(blink_en), 1);
        do_write(6'h30, 8'h07);
        chk("R8 duty code7", int'(duty_pct), 0);
        chk("R14 flash_en off", int'(flash_en), 0);
        do_write(6'h30, 8'h01);
        chk("R8 duty code1", int'(duty_pct), 80);

        // R9 clear
        do_write(6'h30, 8'h82);
        count_busy(n);
        chk("R9 busy length", n, CLR);
        check_read(6'h38, 'h20, "R9 char0 blank");
        check_read(6'h3F, 'h20, "R9 char7 blank");
        check_read(6'h03, 0, "R9 flash cleared");
        check_read(6'h30, 'h02, "R9 ctrl stored");

        // R12 writes while busy
        do_write(6'h30, 8'h80);
        do_write(6'h38, 8'h44);
        do_write(6'h30, 8'h05);
        wait_idle();
        check_read(6'h38, 'h20, "R12 char write dropped");
        check_read(6'h30, 'h00, "R12 ctrl write dropped");

        // R10 self-test
        do_write(6'h30, 8'h41);
        count_busy(n);
        chk("R10 test length", n, TST);
        check_read(6'h30, 'h21, "R10 result");
        do_write(6'h30, 8'h40);
        check_read(6'h30, 'h40, "R10 running bit");
        wait_idle();
        check_read(6'h30, 'h20, "R10 result again");

        // R11 clear and test together
        do_write(6'h30, 8'hC3);
        count_busy(n);
        chk("R11 busy is clear length", n, CLR);
        check_read(6'h30, 'h23, "R11 no test");

        // R13 module reset
        do_write(6'h38, 8'h5A);
        @(posedge clk); #1 ce_n = 1'b0; disp_rst_n = 1'b0;
        repeat (3) begin
            @(negedge clk);
            chk("R13 ce low ignored busy", int'(busy), 0);
        end
        @(posedge clk); #1 ce_n = 1'b1; disp_rst_n = 1'b1;
        check_read(6'h38, 'h5A, "R13 ce low kept char");
        @(posedge clk); #1 disp_rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1 disp_rst_n = 1'b1;
        count_busy(n);
        chk("R13 busy after release", n, CLR + 1);
        check_read(6'h38, 'h20, "R13 char reset");
        check_read(6'h30, 'h00, "R13 ctrl reset");
        check_read(6'h20, 0, "R13 ptr reset");
        do_write(6'h20, 8'h05);
        check_read(6'h2A, 'h1F, "R13 rows kept");

        repeat (2) @(posedge clk);
        finish_run();
    end

endmodule